// File: doc/BRIEF.md
# Acquisition Control and Event Status Register Group

This block holds the control, command and status registers of a data acquisition front end. A host writes a control byte that picks the pacer clock source, the expansion option, two interrupt enables and the trigger mode, source and edge. The same address, when read, returns a status byte. That status byte merges live level signals from the sequencer and FIFO (idle, running, full, near-full, empty) with three sticky event flags: data lost, end of scan and FIFO threshold.

A second address takes command bytes. Its five upper bits are one-shot actions: arm, FIFO clear, queue clear, stop and latch. Each one goes out as a single-cycle pulse to the sequencer. Its three lower bits, a two-bit burst rate and a FIFO-data select, are stored and hold their value until the next command write. Reading the status address clears the sticky events. An event that arrives during that same read is kept. A single interrupt line combines the events with their enables.

Top module: `acq_csr_group`

## Requirements
- R1: After reset every control field, the burst rate, the FIFO-data select, every pulse output, every event flag, `irq` and `rdata` are 0.
- R2: A write to the control address stores the byte as bits 7:6 pacer select, bit 5 expansion enable, bit 4 end-of-scan interrupt enable, bit 3 FIFO interrupt enable, bit 2 continuous trigger, bit 1 external trigger and bit 0 falling edge. The fields appear on their outputs in the cycle after the write.
- R3: A read of the control address returns status in `rdata` in the cycle after `rd_en`. The layout is bit 7 idle, bit 6 running, bit 5 data lost, bit 4 end of scan, bit 3 threshold, bit 2 full, bit 1 near-full and bit 0 empty.
- R4: A one-cycle pulse on an event input sets its flag, and the flag stays set until a status read.
- R5: A status read clears all three event flags and leaves the level bits alone.
- R6: An event that arrives in the same cycle as a status read is absent from that read's data and present in the next read.
- R7: A write to the command address drives `cmd_arm`, `cmd_fifo_clr`, `cmd_queue_clr`, `cmd_stop` and `cmd_latch` from bits 7, 6, 5, 4 and 3 for exactly the one cycle after the write.
- R8: Command bits 2:1 (burst rate) and bit 0 (FIFO-data select) are stored and hold their value until the next command write. A read of the command address returns them in bits 2:0, with bits 7:3 reading 0.
- R9: `irq` is high exactly when (end-of-scan flag AND its enable) OR (threshold flag AND FIFO interrupt enable). The data-lost flag never raises it.
- R10: Writing 0 to the control address drops `irq` but keeps the pending event flags, which a later read still returns.
- R11: Writing the control address and reading the command address both leave the event flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| lvl_idle | input | 1 | Sequencer idle level |
| lvl_running | input | 1 | Sequencer running level |
| lvl_full | input | 1 | FIFO full level |
| lvl_near_full | input | 1 | FIFO near-full level |
| lvl_empty | input | 1 | FIFO empty level |
| ev_lost | input | 1 | Data-lost event pulse |
| ev_scan_end | input | 1 | End-of-scan event pulse |
| ev_threshold | input | 1 | FIFO threshold event pulse |
| pacer_sel | output | 2 | Pacer clock select |
| expand_en | output | 1 | Expansion enable |
| scan_irq_en | output | 1 | End-of-scan interrupt enable |
| fifo_irq_en | output | 1 | FIFO interrupt enable |
| trig_continuous | output | 1 | Continuous trigger mode |
| trig_external | output | 1 | External trigger source |
| trig_falling | output | 1 | Falling trigger edge |
| cmd_arm | output | 1 | Arm pulse |
| cmd_fifo_clr | output | 1 | FIFO clear pulse |
| cmd_queue_clr | output | 1 | Queue clear pulse |
| cmd_stop | output | 1 | Stop pulse |
| cmd_latch | output | 1 | Latch pulse |
| burst_rate | output | 2 | Stored burst rate |
| fifo_data_sel | output | 1 | Stored FIFO-data select |
| irq | output | 1 | Combined interrupt request |

## Verification
Each event is raised alone with its matching enable set, then again with the enable cleared. This tells the end-of-scan and threshold paths to `irq` apart from the data-lost path, which must stay silent. One case puts an event in the same cycle as a status read, which separates clearing that wins from clearing that lets the new event through. Command bytes with all pulse bits set and then with a sparse mix check the one-cycle pulse width and bit order, and show that the stored rate and select follow only the latest write. Level inputs switch between reads to confirm that clearing on read touches only the three sticky bits.

// File: rtl/acq_csr_pkg.sv
package acq_csr_pkg;

   typedef struct packed {
      logic [1:0] pacer;
      logic       expand;
      logic       scan_ie;
      logic       fifo_ie;
      logic       trig_cont;
      logic       trig_ext;
      logic       trig_fall;
   } ctrl_t;

   localparam int NUM_PULSE = 5;
   localparam int NUM_EVT   = 3;
   // event vector order matches status bits 5:3
   localparam int EV_THR    = 0;
   localparam int EV_SCAN   = 1;
   localparam int EV_LOST   = 2;

endpackage

// File: rtl/acq_ctrl_store.sv
module acq_ctrl_store
   import acq_csr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl
);
   localparam int CW = $bits(ctrl_t);

   if (DATA_W < CW) begin : g_bad_width
      $error("acq_ctrl_store: DATA_W too narrow");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl <= '0;
      else if (we) ctrl <= ctrl_t'(wdata[CW-1:0]);
   end

   a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(ctrl));
endmodule

// File: rtl/acq_cmd_unit.sv
module acq_cmd_unit
   import acq_csr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int RATE_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [DATA_W-1:0]    wdata,
   output logic [NUM_PULSE-1:0] pulse,
   output logic [RATE_W-1:0]    rate,
   output logic                 fsel
);
   localparam int PULSE_LSB = RATE_W + 1;

   if (PULSE_LSB + NUM_PULSE != DATA_W) begin : g_bad_layout
      $error("acq_cmd_unit: fields do not fill the command byte");
   end

   for (genvar i = 0; i < NUM_PULSE; i++) begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse[i] <= 1'b0;
         else        pulse[i] <= we & wdata[PULSE_LSB+i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate <= '0;
         fsel <= 1'b0;
      end else if (we) begin
         rate <= wdata[RATE_W:1];
         fsel <= wdata[0];
      end
   end

   a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> (pulse == '0));
   a_r8_rate_persist: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(rate) && $stable(fsel)));
endmodule

// File: rtl/acq_event_cell.sv
module acq_event_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);
endmodule

// File: rtl/acq_csr_group.sv
module acq_csr_group
   import acq_csr_pkg::*;
#(
   parameter int          ADDR_W   = 4,
   parameter int          DATA_W   = 8,
   parameter int          RATE_W   = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h2,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 4'h7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              lvl_idle,
   input  logic              lvl_running,
   input  logic              lvl_full,
   input  logic              lvl_near_full,
   input  logic              lvl_empty,
   input  logic              ev_lost,
   input  logic              ev_scan_end,
   input  logic              ev_threshold,
   output logic [1:0]        pacer_sel,
   output logic              expand_en,
   output logic              scan_irq_en,
   output logic              fifo_irq_en,
   output logic              trig_continuous,
   output logic              trig_external,
   output logic              trig_falling,
   output logic              cmd_arm,
   output logic              cmd_fifo_clr,
   output logic              cmd_queue_clr,
   output logic              cmd_stop,
   output logic              cmd_latch,
   output logic [RATE_W-1:0] burst_rate,
   output logic              fifo_data_sel,
   output logic              irq
);
   localparam int CMD_KEEP_W = RATE_W + 1;

   if (CTRL_ADDR == CMD_ADDR) begin : g_bad_map
      $error("acq_csr_group: control and command addresses collide");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("acq_csr_group: status layout needs an 8-bit bus");
   end

   logic ctrl_hit, cmd_hit, ctrl_wr, cmd_wr, stat_rd, cmd_rd;
   assign ctrl_hit = (addr == CTRL_ADDR);
   assign cmd_hit  = (addr == CMD_ADDR);
   assign ctrl_wr  = wr_en & ctrl_hit;
   assign cmd_wr   = wr_en & cmd_hit;
   assign stat_rd  = rd_en & ctrl_hit;
   assign cmd_rd   = rd_en & cmd_hit;

   ctrl_t ctrl;
   acq_ctrl_store #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(ctrl_wr), .wdata(wdata), .ctrl(ctrl)
   );

   logic [NUM_PULSE-1:0] pulse;
   acq_cmd_unit #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .we(cmd_wr), .wdata(wdata),
      .pulse(pulse), .rate(burst_rate), .fsel(fifo_data_sel)
   );

   logic [NUM_EVT-1:0] ev_in, ev_flag;
   assign ev_in[EV_THR]  = ev_threshold;
   assign ev_in[EV_SCAN] = ev_scan_end;
   assign ev_in[EV_LOST] = ev_lost;

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      acq_event_cell u_cell (
         .clk(clk), .rst_n(rst_n), .set(ev_in[e]), .clr(stat_rd),
         .flag(ev_flag[e])
      );
   end

   logic [DATA_W-1:0] status_word, cmd_word, rd_next;
   assign status_word = {lvl_idle, lvl_running, ev_flag,
                         lvl_full, lvl_near_full, lvl_empty};
   assign cmd_word    = {{(DATA_W-CMD_KEEP_W){1'b0}}, burst_rate, fifo_data_sel};

   always_comb begin
      rd_next = '0;
      if (stat_rd)     rd_next = status_word;
      else if (cmd_rd) rd_next = cmd_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

   assign pacer_sel       = ctrl.pacer;
   assign expand_en       = ctrl.expand;
   assign scan_irq_en     = ctrl.scan_ie;
   assign fifo_irq_en     = ctrl.fifo_ie;
   assign trig_continuous = ctrl.trig_cont;
   assign trig_external   = ctrl.trig_ext;
   assign trig_falling    = ctrl.trig_fall;

   // pulse vector index i comes from command bit 3+i
   assign cmd_latch     = pulse[0];
   assign cmd_stop      = pulse[1];
   assign cmd_queue_clr = pulse[2];
   assign cmd_fifo_clr  = pulse[3];
   assign cmd_arm       = pulse[4];

   assign irq = (ev_flag[EV_SCAN] & ctrl.scan_ie) |
                (ev_flag[EV_THR]  & ctrl.fifo_ie);

   a_r10_zero_ctrl_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wdata == '0) |=> !irq);
   a_r9_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ev_flag[EV_SCAN] || ev_flag[EV_THR]));
   a_r11_ctrl_wr_keeps_events: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !rd_en && ev_in == '0) |=> $stable(ev_flag));
   a_r3_read_returns_levels: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (rdata[7] == $past(lvl_idle) && rdata[0] == $past(lvl_empty)));
endmodule

// File: tb/tb_acq_csr_group.sv
`timescale 1ns/1ps
module tb_acq_csr_group;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic lvl_idle = 0, lvl_running = 0, lvl_full = 0, lvl_near_full = 0, lvl_empty = 0;
   logic ev_lost = 0, ev_scan_end = 0, ev_threshold = 0;
   logic [1:0] pacer_sel, burst_rate;
   logic expand_en, scan_irq_en, fifo_irq_en, trig_continuous, trig_external, trig_falling;
   logic cmd_arm, cmd_fifo_clr, cmd_queue_clr, cmd_stop, cmd_latch, fifo_data_sel, irq;

   localparam logic [3:0] A_CTRL = 4'h2;
   localparam logic [3:0] A_CMD  = 4'h7;

   always #2.5 clk = ~clk;

   acq_csr_group dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .lvl_idle(lvl_idle), .lvl_running(lvl_running),
      .lvl_full(lvl_full), .lvl_near_full(lvl_near_full), .lvl_empty(lvl_empty),
      .ev_lost(ev_lost), .ev_scan_end(ev_scan_end), .ev_threshold(ev_threshold),
      .pacer_sel(pacer_sel), .expand_en(expand_en), .scan_irq_en(scan_irq_en),
      .fifo_irq_en(fifo_irq_en), .trig_continuous(trig_continuous),
      .trig_external(trig_external), .trig_falling(trig_falling),
      .cmd_arm(cmd_arm), .cmd_fifo_clr(cmd_fifo_clr), .cmd_queue_clr(cmd_queue_clr),
      .cmd_stop(cmd_stop), .cmd_latch(cmd_latch), .burst_rate(burst_rate),
      .fifo_data_sel(fifo_data_sel), .irq(irq)
   );

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_pend = 1'b0;

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: a read strobe seen at an edge delivers data for the next negedge
   always @(posedge clk) rd_pend <= rd_en & rst_n;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) chk(8'hxx, 8'h00, "scoreboard underflow");
         else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); addr = a; rd_en = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic fire(input int which);
      @(negedge clk);
      ev_lost = (which == 2); ev_scan_end = (which == 1); ev_threshold = (which == 0);
      @(negedge clk);
      ev_lost = 0; ev_scan_end = 0; ev_threshold = 0;
   endtask

   function automatic logic [7:0] ctrl_word();
      return {pacer_sel, expand_en, scan_irq_en, fifo_irq_en,
              trig_continuous, trig_external, trig_falling};
   endfunction

   function automatic logic [7:0] pulse_word();
      return {cmd_arm, cmd_fifo_clr, cmd_queue_clr, cmd_stop, cmd_latch, 3'b000};
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ctrl_word(), 8'h00, "R1 ctrl reset");
      chk(pulse_word(), 8'h00, "R1 pulses reset");
      chk({5'b0, burst_rate, fifo_data_sel}, 8'h00, "R1 cmd fields reset");
      chk({7'b0, irq}, 8'h00, "R1 irq reset");
      chk(rdata, 8'h00, "R1 rdata reset");

      // R2 control layout
      wr(A_CTRL, 8'hA5);
      chk(ctrl_word(), 8'hA5, "R2 ctrl A5");
      chk({6'b0, pacer_sel}, 8'h02, "R2 pacer field");
      chk({7'b0, trig_falling}, 8'h01, "R2 edge bit0");
      wr(A_CTRL, 8'h18);
      chk(ctrl_word(), 8'h18, "R2 ctrl 18");

      // R3 level layout
      lvl_idle = 1; lvl_empty = 1;
      rd(A_CTRL, 8'h81, "R3 idle+empty");

      // R4 sticky, R9 scan irq, R5 clear
      fire(1);
      chk({7'b0, irq}, 8'h01, "R9 scan irq");
      repeat (3) @(negedge clk);
      chk({7'b0, irq}, 8'h01, "R4 flag held");
      rd(A_CTRL, 8'h91, "R4 scan flag read");
      chk({7'b0, irq}, 8'h00, "R5 irq drops after read");
      rd(A_CTRL, 8'h81, "R5 cleared on read");

      // R9 threshold, R10 zero control masks but keeps event
      fire(0);
      chk({7'b0, irq}, 8'h01, "R9 threshold irq");
      wr(A_CTRL, 8'h00);
      chk({7'b0, irq}, 8'h00, "R10 zero ctrl masks irq");
      rd(A_CTRL, 8'h89, "R10 event kept");

      // R9 lost never interrupts
      wr(A_CTRL, 8'h18);
      fire(2);
      chk({7'b0, irq}, 8'h00, "R9 lost no irq");
      rd(A_CTRL, 8'hA1, "R4 lost flag read");

      // R6 event during read
      @(negedge clk); addr = A_CTRL; rd_en = 1; ev_scan_end = 1;
      exp_q.push_back(8'h81); tag_q.push_back("R6 same-cycle read");
      @(negedge clk); rd_en = 0; ev_scan_end = 0;
      rd(A_CTRL, 8'h91, "R6 event survives");

      // R7 pulses, R8 persistence
      wr(A_CMD, 8'hFD);
      chk(pulse_word(), 8'hF8, "R7 all pulses");
      chk({5'b0, burst_rate, fifo_data_sel}, 8'h05, "R8 fields stored");
      @(negedge clk);
      chk(pulse_word(), 8'h00, "R7 pulses one cycle");
      chk({5'b0, burst_rate, fifo_data_sel}, 8'h05, "R8 fields hold");
      rd(A_CMD, 8'h05, "R8 cmd readback");
      wr(A_CMD, 8'h4A);
      chk(pulse_word(), 8'h48, "R7 fifo clr + latch");
      chk({5'b0, burst_rate, fifo_data_sel}, 8'h02, "R8 new fields");
      @(negedge clk);
      chk(pulse_word(), 8'h00, "R7 sparse pulses end");

      // R11 ctrl write and cmd read keep events
      fire(0);
      wr(A_CTRL, 8'h10);
      rd(A_CMD, 8'h02, "R11 cmd read data");
      lvl_idle = 0; lvl_running = 1; lvl_full = 1; lvl_near_full = 1; lvl_empty = 0;
      rd(A_CTRL, 8'h4E, "R11 threshold still set");
      rd(A_CTRL, 8'h46, "R5 levels kept, events cleared");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) chk(8'h01, 8'h00, "scoreboard leftover");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule